// File: doc/BRIEF.md
# Core Retention Handshake Controller

This unit sits next to one processor core and decides, cycle by cycle, whether that core's clock runs. When the core reports that it is parked in a wait-for-interrupt or wait-for-event sleep state, the unit drops the clock enable. It also pulls `ret_active` low to tell an external power controller that the core could be moved to a retention voltage. The controller asks for retention by pulling `ret_req_n` low. The unit grants the request by pulling `ret_accept_n` low. From then on, the clock stays stopped until the controller lets go of the request.

Outside retention, the unit may briefly restart the clock while the core is still asleep, so that coherence snoops can be served. An interrupt or a generic wake event brings the core back to full run. When a snoop, interrupt or wake event arrives during retention, the unit raises `ret_active` to ask for exit and remembers the event. The remembered event is served once the controller has released the request and the grant has been withdrawn. Every asynchronous input passes through a two-stage synchronizer, so an input change acts on the state three clock edges after it is driven.

Top module: `core_retention_ctrl`

## Requirements
- R1: During and right after the synchronous active-high reset, with the core awake, `core_clk_en`=1, `ret_active`=1 and `ret_accept_n`=1.
- R2: When `core_sleep` rises and no event is present, the next cycle shows `core_clk_en`=0 and `ret_active`=0, with `ret_accept_n` still 1.
- R3: A snoop that arrives while the core sleeps outside retention enables the clock with `ret_active`=1 three cycles after `snoop_req` rises. The clock stops again three cycles after `snoop_req` falls. A snoop left pending from retention is served the same way, right after exit.
- R4: With the core asleep, the clock stopped and no event present, `ret_accept_n` goes low three cycles after `ret_req_n` is driven low. That is two cycles of synchronization plus one registered decision.
- R5: While a snoop holds the clock running, a low `ret_req_n` is not granted. `ret_accept_n` stays 1 and is only asserted once the clock has stopped again.
- R6: While `ret_accept_n` is low, `core_clk_en` stays 0 whatever events arrive, for as long as the synchronized request stays low.
- R7: An event that arrives during retention drives `ret_active` to 1 as soon as it leaves the synchronizer. `ret_active` remains 1 after the input pulse ends.
- R8: After `ret_req_n` returns high, `ret_accept_n` returns to 1 three cycles later. `core_clk_en` can rise only in a cycle after `ret_accept_n` is already 1. A pending interrupt or wake event re-enables the clock one cycle after the grant is withdrawn.
- R9: An interrupt that arrives while the core sleeps outside retention raises `ret_active` two cycles after `irq_req` rises, with the clock still off. The clock is enabled on the following cycle.
- R10: `ret_accept_n` is never released while the synchronized request is still low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on controller clock |
| rst | input | 1 | Synchronous active-high reset |
| core_sleep | input | 1 | Core is parked in its wait-for-interrupt or wait-for-event state (synchronous) |
| snoop_req | input | 1 | Coherence snoop needs the core clock (asynchronous) |
| irq_req | input | 1 | Interrupt for this core (asynchronous) |
| wake_req | input | 1 | Generic wake event for this core (asynchronous) |
| ret_req_n | input | 1 | Retention request from the power controller, active low (asynchronous) |
| ret_accept_n | output | 1 | Retention grant, active low |
| ret_active | output | 1 | High when the core needs its clock; low when retention is possible |
| core_clk_en | output | 1 | Enable for the core clock gate |

## Verification
The hardest situation to reach is an event that lands while the grant is held and is still pending when the controller releases the request. In that case the pending memory, the exit step and the choice between full wake and snoop service all act in the same few cycles. The stimulus first grants retention, then sends a one-cycle pulse of the wake or snoop input. This pulse is too short to be seen at the outputs except through the pending memory. The stimulus holds the request for several more cycles and then releases it. The refused-request case is reached by raising the snoop and the request on the same cycle, so the snoop wins the priority check.

// File: rtl/core_ret_pkg.sv
package core_ret_pkg;

    typedef enum logic [2:0] {
        CR_RUN     = 3'd0,
        CR_PARKED  = 3'd1,
        CR_SNOOP   = 3'd2,
        CR_HELD    = 3'd3,
        CR_LEAVING = 3'd4
    } cr_state_e;

    typedef struct packed {
        logic snoop;
        logic wake;
    } cr_evt_t;

    typedef struct packed {
        logic clk_en;
        logic active;
        logic accept_n;
    } cr_out_t;

    localparam int CR_SYNC_DEFAULT = 2;

    function automatic logic cr_evt_any(input cr_evt_t e);
        return e.snoop | e.wake;
    endfunction

    function automatic cr_out_t cr_decode(input cr_state_e st,
                                          input cr_evt_t   live,
                                          input cr_evt_t   pend,
                                          input logic      sleep);
        cr_out_t o;
        o = '{clk_en: 1'b1, active: 1'b1, accept_n: 1'b1};
        unique case (st)
            CR_RUN, CR_SNOOP: ;
            CR_PARKED: begin
                o.clk_en = 1'b0;
                o.active = cr_evt_any(live) | ~sleep;
            end
            CR_HELD: begin
                o.clk_en   = 1'b0;
                o.active   = cr_evt_any(live) | cr_evt_any(pend);
                o.accept_n = 1'b0;
            end
            CR_LEAVING: begin
                o.clk_en = 1'b0;
                o.active = cr_evt_any(live) | cr_evt_any(pend) | ~sleep;
            end
            default: ;
        endcase
        return o;
    endfunction

endpackage

// File: rtl/core_ret_sync.sv
module core_ret_sync #(
    parameter int                 WIDTH     = 4,
    parameter int                 STAGES    = 2,
    parameter logic [WIDTH-1:0]   RESET_VAL = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d_async,
    output logic [WIDTH-1:0] q_sync
);
    logic [WIDTH-1:0] chain [STAGES];

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst)
                    chain[s] <= RESET_VAL;
                else if (s == 0)
                    chain[s] <= d_async;
                else
                    chain[s] <= chain[(s == 0) ? 0 : s-1];
            end
        end
    endgenerate

    assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/core_ret_pending.sv
module core_ret_pending
    import core_ret_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    capture,
    input  logic    clear,
    input  cr_evt_t evt_in,
    output cr_evt_t pend
);
    always_ff @(posedge clk) begin
        if (rst || clear)
            pend <= '0;
        else if (capture)
            pend <= pend | evt_in;
    end
endmodule

// File: rtl/core_ret_fsm.sv
module core_ret_fsm
    import core_ret_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      sleep,
    input  logic      req_n_s,
    input  cr_evt_t   live,
    input  cr_evt_t   pend,
    output cr_state_e state,
    output logic      capture,
    output logic      clear
);
    cr_state_e nxt;

    always_comb begin
        nxt = state;
        unique case (state)
            CR_RUN:
                if (sleep && !cr_evt_any(live)) nxt = CR_PARKED;
            CR_PARKED:
                if (!sleep || live.wake)   nxt = CR_RUN;
                else if (live.snoop)       nxt = CR_SNOOP;
                else if (!req_n_s)         nxt = CR_HELD;
            CR_SNOOP:
                if (!sleep || live.wake)   nxt = CR_RUN;
                else if (!live.snoop)      nxt = CR_PARKED;
            CR_HELD:
                if (req_n_s)               nxt = CR_LEAVING;
            CR_LEAVING:
                if (!sleep || live.wake || pend.wake)  nxt = CR_RUN;
                else if (live.snoop || pend.snoop)     nxt = CR_SNOOP;
                else                                   nxt = CR_PARKED;
            default: nxt = CR_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= CR_RUN;
        else     state <= nxt;
    end

    assign capture = (state == CR_HELD) || (state == CR_LEAVING);
    assign clear   = (state == CR_RUN)  || (state == CR_SNOOP);
endmodule

// File: rtl/core_retention_ctrl.sv
module core_retention_ctrl
    import core_ret_pkg::*;
#(
    parameter int SYNC_STAGES = CR_SYNC_DEFAULT
) (
    input  logic clk,
    input  logic rst,
    input  logic core_sleep,
    input  logic snoop_req,
    input  logic irq_req,
    input  logic wake_req,
    input  logic ret_req_n,
    output logic ret_accept_n,
    output logic ret_active,
    output logic core_clk_en
);
    localparam int          NSYNC   = 4;
    localparam logic [NSYNC-1:0] SYNC_RST = 4'b1000;

    logic [NSYNC-1:0] raw_in, synced;
    logic             req_n_s;
    logic             evt_any_s;
    cr_evt_t          live, pend;
    cr_state_e        state;
    logic             capture, clear;
    cr_out_t          outs;

    assign raw_in = {ret_req_n, wake_req, irq_req, snoop_req};

    core_ret_sync #(
        .WIDTH    (NSYNC),
        .STAGES   (SYNC_STAGES),
        .RESET_VAL(SYNC_RST)
    ) u_sync (
        .clk    (clk),
        .rst    (rst),
        .d_async(raw_in),
        .q_sync (synced)
    );

    assign req_n_s    = synced[3];
    assign live.wake  = synced[2] | synced[1];
    assign live.snoop = synced[0];
    assign evt_any_s  = cr_evt_any(live);

    core_ret_pending u_pend (
        .clk    (clk),
        .rst    (rst),
        .capture(capture),
        .clear  (clear),
        .evt_in (live),
        .pend   (pend)
    );

    core_ret_fsm u_fsm (
        .clk    (clk),
        .rst    (rst),
        .sleep  (core_sleep),
        .req_n_s(req_n_s),
        .live   (live),
        .pend   (pend),
        .state  (state),
        .capture(capture),
        .clear  (clear)
    );

    assign outs         = cr_decode(state, live, pend, core_sleep);
    assign core_clk_en  = outs.clk_en;
    assign ret_active   = outs.active;
    assign ret_accept_n = outs.accept_n;
endmodule

// File: rtl/core_ret_chk.sv
module core_ret_chk (
    input logic clk,
    input logic rst,
    input logic req_n_s,
    input logic evt_any_s,
    input logic clk_en,
    input logic active,
    input logic accept_n
);
    AST_HELD_CLOCK_OFF: assert property (@(posedge clk) disable iff (rst)
        !accept_n |-> !clk_en);                                           // R6

    AST_GRANT_NOT_EARLY_RELEASE: assert property (@(posedge clk) disable iff (rst)
        (!accept_n && !req_n_s) |=> !accept_n);                           // R10

    AST_GRANT_NEEDS_QUIET: assert property (@(posedge clk) disable iff (rst)
        $fell(accept_n) |-> $past(!active && !clk_en));                   // R5

    AST_RELEASE_NEXT: assert property (@(posedge clk) disable iff (rst)
        (!accept_n && req_n_s) |=> accept_n);                             // R8

    AST_CLOCK_AFTER_RELEASE: assert property (@(posedge clk) disable iff (rst)
        $rose(clk_en) |-> $past(accept_n));                               // R8

    AST_EVENT_ASKS_EXIT: assert property (@(posedge clk) disable iff (rst)
        (!accept_n && evt_any_s) |-> active);                             // R7
endmodule

bind core_retention_ctrl core_ret_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .req_n_s  (req_n_s),
    .evt_any_s(evt_any_s),
    .clk_en   (core_clk_en),
    .active   (ret_active),
    .accept_n (ret_accept_n)
);

// File: tb/core_retention_ctrl_test.sv
`timescale 1ns/1ps
module core_retention_ctrl_test;
    logic clk = 1'b0;
    logic rst, core_sleep, snoop_req, irq_req, wake_req, ret_req_n;
    logic ret_accept_n, ret_active, core_clk_en;

    always #2 clk = ~clk;

    core_retention_ctrl uut (
        .clk(clk), .rst(rst), .core_sleep(core_sleep), .snoop_req(snoop_req),
        .irq_req(irq_req), .wake_req(wake_req), .ret_req_n(ret_req_n),
        .ret_accept_n(ret_accept_n), .ret_active(ret_active), .core_clk_en(core_clk_en)
    );

    typedef struct {
        int    at;
        logic  en;
        logic  act;
        logic  acc;
        string tag;
    } exp_t;

    exp_t q[$];
    int   cyc = 0;
    int   n_run = 0;
    int   n_fail = 0;
    bit   done = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic expect_at(input int d, input logic en, input logic act,
                             input logic acc, input string tag);
        exp_t e;
        e.at = cyc + d; e.en = en; e.act = act; e.acc = acc; e.tag = tag;
        q.push_back(e);
    endtask

    // monitor: compares at the falling edge, away from the active edge
    always @(negedge clk) begin
        while (q.size() > 0 && q[0].at <= cyc) begin
            exp_t e;
            e = q.pop_front();
            n_run++;
            if (e.at != cyc || core_clk_en !== e.en || ret_active !== e.act ||
                ret_accept_n !== e.acc) begin
                n_fail++;
                $display("FAIL %s cyc %0d: got en=%b act=%b acc_n=%b, expected en=%b act=%b acc_n=%b",
                         e.tag, cyc, core_clk_en, ret_active, ret_accept_n,
                         e.en, e.act, e.acc);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; core_sleep = 1'b0; snoop_req = 1'b0; irq_req = 1'b0;
        wake_req = 1'b0; ret_req_n = 1'b1;
        tick(3);
        expect_at(0, 1, 1, 1, "R1 in reset");
        rst = 1'b0;
        expect_at(1, 1, 1, 1, "R1 after reset");
        tick(3);

        // R2: sleep with no events
        core_sleep = 1'b1;
        expect_at(1, 0, 0, 1, "R2");
        tick(3);

        // R3: snoop outside retention
        snoop_req = 1'b1;
        expect_at(2, 0, 1, 1, "R3 asks");
        expect_at(3, 1, 1, 1, "R3 clock on");
        tick(5);
        snoop_req = 1'b0;
        expect_at(3, 0, 0, 1, "R3 clock off");
        tick(5);

        // R4: grant
        ret_req_n = 1'b0;
        expect_at(2, 0, 0, 1, "R4 not yet");
        expect_at(3, 0, 0, 0, "R4 granted");
        tick(4);

        // R7/R6: wake pulse in retention
        wake_req = 1'b1;
        tick(1);
        wake_req = 1'b0;
        expect_at(1, 0, 1, 0, "R7 raised");
        expect_at(2, 0, 1, 0, "R7 held");
        expect_at(8, 0, 1, 0, "R6 clock stays off");
        tick(10);

        // R8: release, pending wake resumes run
        ret_req_n = 1'b1;
        expect_at(2, 0, 1, 0, "R8 grant kept");
        expect_at(3, 0, 1, 1, "R8 grant dropped");
        expect_at(4, 1, 1, 1, "R8 clock after release");
        tick(4);
        core_sleep = 1'b0;
        tick(3);

        // R9: interrupt outside retention
        core_sleep = 1'b1;
        tick(2);
        irq_req = 1'b1;
        expect_at(2, 0, 1, 1, "R9 active first");
        expect_at(3, 1, 1, 1, "R9 clock next");
        tick(3);
        irq_req = 1'b0;
        core_sleep = 1'b0;
        tick(4);

        // R5: request refused while snoop runs the clock
        core_sleep = 1'b1;
        tick(2);
        snoop_req = 1'b1;
        ret_req_n = 1'b0;
        expect_at(3, 1, 1, 1, "R5 refused");
        expect_at(6, 1, 1, 1, "R5 still refused");
        tick(7);
        snoop_req = 1'b0;
        expect_at(3, 0, 0, 1, "R5 clock stopped");
        expect_at(4, 0, 0, 0, "R4 late grant");
        tick(6);

        // snoop in retention, served after exit
        snoop_req = 1'b1;
        tick(1);
        snoop_req = 1'b0;
        expect_at(1, 0, 1, 0, "R7 snoop raised");
        expect_at(4, 0, 1, 0, "R6 snoop no clock");
        tick(5);
        ret_req_n = 1'b1;
        expect_at(3, 0, 1, 1, "R8 grant dropped");
        expect_at(4, 1, 1, 1, "R3 pending snoop served");
        expect_at(5, 0, 0, 1, "R3 back to parked");
        tick(8);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule